// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Byte Codec

This block protects a data byte on its way into and out of a memory array. On the write side it turns the byte into a 12-bit Hamming codeword and adds a 13th bit that makes the parity of the whole word even. On the read side it takes a fetched 13-bit word and recomputes the four check bits. It XORs them with the stored ones to form a syndrome that names the bit position in error. It then repairs a single flipped bit, or it raises a flag that the word cannot be trusted.

Codeword bit `k` of a port vector holds position `k+1`. The check bits sit at the power-of-two positions, the data bits fill the other positions in ascending order, and the overall-parity bit is vector bit 12. The two paths are independent and may be used in the same cycle. By default both paths end in a register stage, so results appear one clock after their inputs. The register can be removed by parameter, and the overall-parity bit can be dropped to give correction only.

Top module: `secded_codec`

## Requirements
- R1: In `wr_code`, check bits C1, C2, C4 and C8 sit at bits [0], [1], [3] and [7], and data bits `wr_data[0]` to `wr_data[7]` sit at bits [2], [4], [5], [6], [8], [9], [10] and [11] in that order. For example, `wr_data = 8'h01` gives `wr_code = 13'h1007`.
- R2: Each check bit at position 2^k is the even parity of the data bits whose 1-based position has bit k set. For example, `wr_data = 8'hFF` gives `wr_code[11:0] = 12'hF77`.
- R3: `wr_code[12]` is the even parity of `wr_code[11:0]`, so every encoded word has an even number of ones.
- R4: A read word equal to the encoding of byte D returns `rd_data = D`, with both flags low.
- R5: A read word with exactly one flipped bit among bits [11:0] returns the original byte with `rd_corrected = 1` and `rd_uncorrectable = 0`.
- R6: A read word whose only flipped bit is bit [12] returns the original byte with `rd_corrected = 1` and `rd_uncorrectable = 0`.
- R7: A read word with two flipped bits anywhere in [12:0] sets `rd_uncorrectable = 1` and `rd_corrected = 0`. `rd_data` is then the data bits of the read word taken from the R1 positions without any repair.
- R8: A read word whose syndrome is 13, 14 or 15 sets `rd_uncorrectable = 1` and `rd_corrected = 0`, even when the overall parity mismatches. `rd_data` is left unrepaired.
- R9: `rd_corrected` and `rd_uncorrectable` are never high together.
- R10: With the default register stage, every output changes only at the rising clock edge after its input was applied. While `rst_n` is low, all outputs are zero.
- R11: The write path and the read path work at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Active-low asynchronous reset, clears the outputs |
| wr_data | input | 8 | Byte to encode |
| wr_code | output | 13 | Encoded word; bit 12 is the overall parity |
| rd_code | input | 13 | Word fetched from storage |
| rd_data | output | 8 | Decoded, and if possible repaired, byte |
| rd_corrected | output | 1 | A single error was found and repaired |
| rd_uncorrectable | output | 1 | An error was found that cannot be repaired |

## Verification
Every result of the block, `wr_code`, `rd_data` and both flags, is due exactly one rising edge after its inputs are applied. The bench therefore changes inputs on the falling edge and samples one time unit after the next rising edge. One directed case also samples just before that edge to confirm that the old result still holds. Reset is checked both during the initial hold and by an asynchronous assertion mid-run, with outputs sampled while `rst_n` is low.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // number of Hamming check bits needed for dw data bits
    function automatic int chk_bits(input int dw);
        int k;
        k = 0;
        while ((1 << k) < dw + k + 1) k++;
        return k;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // 1-based codeword position of 0-based data bit j
    function automatic int data_pos(input int j);
        int p;
        int cnt;
        p = 0;
        cnt = -1;
        while (cnt < j) begin
            p++;
            if (!is_pow2(p)) cnt++;
        end
        return p;
    endfunction

    // does 1-based position p fall under check bit k
    function automatic bit covers(input int p, input int k);
        return ((p >> k) & 1) != 0;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder #(
    parameter int DATA_W      = 8,
    parameter bit USE_OVERALL = 1'b1,
    localparam int CHK_W      = secded_pkg::chk_bits(DATA_W),
    localparam int CW_W       = DATA_W + CHK_W,
    localparam int TOT_W      = CW_W + (USE_OVERALL ? 1 : 0)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [TOT_W-1:0]  code_o
);

    logic [CW_W-1:0]             placed;
    logic [CHK_W-1:0][CW_W-1:0]  terms;
    logic [CHK_W-1:0]            chk;
    logic [CW_W-1:0]             cw;

    // data bits into the non power-of-two positions, zeros elsewhere
    for (genvar j = 0; j < DATA_W; j++) begin : g_place
        localparam int POS = secded_pkg::data_pos(j);
        assign placed[POS-1] = data_i[j];
    end
    for (genvar p = 0; p < CW_W; p++) begin : g_hole
        if (secded_pkg::is_pow2(p + 1)) begin : g_zero
            assign placed[p] = 1'b0;
        end
    end

    // even parity per check bit over the positions it covers
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        for (genvar p = 0; p < CW_W; p++) begin : g_term
            if (secded_pkg::covers(p + 1, k)) begin : g_on
                assign terms[k][p] = placed[p];
            end else begin : g_off
                assign terms[k][p] = 1'b0;
            end
        end
        assign chk[k] = ^terms[k];
    end

    for (genvar p = 0; p < CW_W; p++) begin : g_word
        if (secded_pkg::is_pow2(p + 1)) begin : g_cbit
            assign cw[p] = chk[$clog2(p + 1)];
        end else begin : g_dbit
            assign cw[p] = placed[p];
        end
    end

    if (USE_OVERALL) begin : g_ovp
        assign code_o = {^cw, cw};
    end else begin : g_noovp
        assign code_o = cw;
    end

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
    parameter int DATA_W      = 8,
    parameter bit USE_OVERALL = 1'b1,
    localparam int CHK_W      = secded_pkg::chk_bits(DATA_W),
    localparam int CW_W       = DATA_W + CHK_W,
    localparam int TOT_W      = CW_W + (USE_OVERALL ? 1 : 0)
) (
    input  logic [TOT_W-1:0] code_i,
    output logic [CHK_W-1:0] syn_o,
    output logic             par_err_o
);

    logic [CHK_W-1:0][CW_W-1:0] terms;

    // covering the stored check bit too folds stored XOR recomputed into one parity
    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        for (genvar p = 0; p < CW_W; p++) begin : g_term
            if (secded_pkg::covers(p + 1, k)) begin : g_on
                assign terms[k][p] = code_i[p];
            end else begin : g_off
                assign terms[k][p] = 1'b0;
            end
        end
        assign syn_o[k] = ^terms[k];
    end

    if (USE_OVERALL) begin : g_ovp
        assign par_err_o = ^code_i;
    end else begin : g_noovp
        assign par_err_o = 1'b0;
    end

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector #(
    parameter int DATA_W      = 8,
    parameter bit USE_OVERALL = 1'b1,
    localparam int CHK_W      = secded_pkg::chk_bits(DATA_W),
    localparam int CW_W       = DATA_W + CHK_W,
    localparam int TOT_W      = CW_W + (USE_OVERALL ? 1 : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOT_W-1:0]  code_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic              par_err_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corrected_o,
    output logic              uncorr_o
);

    localparam logic [CHK_W-1:0] LAST = CHK_W'(CW_W);

    logic              syn_nz;
    logic              in_range;
    logic              single;
    logic              ovp_only;
    logic [CW_W-1:0]   flip;
    logic [CW_W-1:0]   fixed;
    logic [DATA_W-1:0] raw;

    assign syn_nz   = |syn_i;
    assign in_range = (syn_i <= LAST);

    if (USE_OVERALL) begin : g_dec_ded
        assign single   = syn_nz & par_err_i & in_range;
        assign ovp_only = ~syn_nz & par_err_i;
        assign uncorr_o = syn_nz & (~par_err_i | ~in_range);
    end else begin : g_dec_sec
        assign single   = syn_nz & in_range;
        assign ovp_only = 1'b0;
        assign uncorr_o = syn_nz & ~in_range;
    end

    assign corrected_o = single | ovp_only;

    for (genvar p = 0; p < CW_W; p++) begin : g_flip
        assign flip[p] = single & (syn_i == CHK_W'(p + 1));
    end
    assign fixed = code_i[CW_W-1:0] ^ flip;

    for (genvar j = 0; j < DATA_W; j++) begin : g_pick
        localparam int POS = secded_pkg::data_pos(j);
        assign data_o[j] = fixed[POS-1];
        assign raw[j]    = code_i[POS-1];
    end

    // R9: the two verdicts exclude each other
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(corrected_o && uncorr_o));

    // R7, R8: an untrusted word is handed on exactly as fetched
    p_uncorr_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_o |-> (data_o == raw));

    // R5: a repair touches at most one data bit
    p_single_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (corrected_o && syn_nz) |-> ($countones(data_o ^ raw) <= 1));

    // R6: an error confined to the parity bit leaves the data alone
    p_ovp_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (corrected_o && !syn_nz) |-> (data_o == raw));

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
    parameter int DATA_W      = 8,
    parameter bit USE_OVERALL = 1'b1,
    parameter bit REG_OUT     = 1'b1,
    localparam int CHK_W      = secded_pkg::chk_bits(DATA_W),
    localparam int CW_W       = DATA_W + CHK_W,
    localparam int TOT_W      = CW_W + (USE_OVERALL ? 1 : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TOT_W-1:0]  wr_code,
    input  logic [TOT_W-1:0]  rd_code,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_corrected,
    output logic              rd_uncorrectable
);

    typedef struct packed {
        logic [TOT_W-1:0]  code;
        logic [DATA_W-1:0] data;
        logic              corrected;
        logic              uncorr;
    } res_t;

    res_t res_d;
    res_t res_q;

    logic [TOT_W-1:0]  enc_code;
    logic [CHK_W-1:0]  syn;
    logic              par_err;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr;
    logic              dec_unc;

    secded_encoder #(.DATA_W(DATA_W), .USE_OVERALL(USE_OVERALL)) u_enc (
        .data_i (wr_data),
        .code_o (enc_code)
    );

    secded_syndrome #(.DATA_W(DATA_W), .USE_OVERALL(USE_OVERALL)) u_syn (
        .code_i    (rd_code),
        .syn_o     (syn),
        .par_err_o (par_err)
    );

    secded_corrector #(.DATA_W(DATA_W), .USE_OVERALL(USE_OVERALL)) u_cor (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_i      (rd_code),
        .syn_i       (syn),
        .par_err_i   (par_err),
        .data_o      (dec_data),
        .corrected_o (dec_corr),
        .uncorr_o    (dec_unc)
    );

    always_comb begin
        res_d           = '0;
        res_d.code      = enc_code;
        res_d.data      = dec_data;
        res_d.corrected = dec_corr;
        res_d.uncorr    = dec_unc;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        // R10: the first sample after reset still shows the cleared stage
        p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (res_q == '0));
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign wr_code          = res_q.code;
    assign rd_data          = res_q.data;
    assign rd_corrected     = res_q.corrected;
    assign rd_uncorrectable = res_q.uncorr;

    // R4: a word that matches the encoder's own output decodes clean to its byte
    p_roundtrip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code == enc_code) |-> (dec_data == wr_data && !dec_corr && !dec_unc));

endmodule

// File: tb/sim_secded_codec.sv
module sim_secded_codec;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;
    localparam int DPOS [8]   = '{3, 5, 6, 7, 9, 10, 11, 12};

    // {data, flip mask, class: 0 clean, 1 corrected, 2 uncorrectable}
    localparam logic [22:0] VEC [NVEC] = '{
        {8'hA5, 13'h0000, 2'd0},   // R4
        {8'h00, 13'h0000, 2'd0},   // R4
        {8'hFF, 13'h0000, 2'd0},   // R4
        {8'hA5, 13'h0001, 2'd1},   // R5 position 1
        {8'h3C, 13'h0020, 2'd1},   // R5 position 6
        {8'hC3, 13'h0800, 2'd1},   // R5 position 12
        {8'h5A, 13'h0080, 2'd1},   // R5 position 8
        {8'h81, 13'h0004, 2'd1},   // R5 position 3
        {8'hE7, 13'h0400, 2'd1},   // R5 position 11
        {8'h7E, 13'h1000, 2'd1},   // R6 parity bit only
        {8'hA5, 13'h0021, 2'd2},   // R7 positions 1 and 6
        {8'h0F, 13'h1001, 2'd2},   // R7 parity bit and position 1
        {8'hF0, 13'h0C00, 2'd2},   // R7 positions 11 and 12
        {8'h5A, 13'h0006, 2'd2},   // R7 positions 2 and 3
        {8'h96, 13'h0089, 2'd2},   // R8 syndrome 13
        {8'h69, 13'h0803, 2'd2}    // R8 syndrome 15
    };

    logic        clk;
    logic        rst_n;
    logic [7:0]  wr_data;
    logic [12:0] wr_code;
    logic [12:0] rd_code;
    logic [7:0]  rd_data;
    logic        rd_corrected;
    logic        rd_uncorrectable;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    secded_codec u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_data          (wr_data),
        .wr_code          (wr_code),
        .rd_code          (rd_code),
        .rd_data          (rd_data),
        .rd_corrected     (rd_corrected),
        .rd_uncorrectable (rd_uncorrectable)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [12:0] ref_enc(input logic [7:0] d);
        logic [12:0] w;
        logic        p;
        w = '0;
        for (int j = 0; j < 8; j++) w[DPOS[j]-1] = d[j];
        for (int k = 0; k < 4; k++) begin
            p = 1'b0;
            for (int pos = 1; pos <= 12; pos++)
                if (((pos >> k) & 1) != 0) p = p ^ w[pos-1];
            w[(1 << k) - 1] = p;
        end
        w[12] = ^w[11:0];
        return w;
    endfunction

    function automatic logic [7:0] ref_pick(input logic [12:0] w);
        logic [7:0] d;
        for (int j = 0; j < 8; j++) d[j] = w[DPOS[j]-1];
        return d;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [7:0]  d;
        logic [12:0] flip;
        logic [1:0]  cls;
        logic [7:0]  exp_d;

        rst_n   = 1'b0;
        wr_data = 8'hFF;
        rd_code = 13'h1FFF;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset wr_code", 32'(wr_code), 32'h0);
        check("R10 reset rd_data", 32'(rd_data), 32'h0);
        check("R10 reset corrected", 32'(rd_corrected), 32'h0);
        check("R10 reset uncorrectable", 32'(rd_uncorrectable), 32'h0);

        @(negedge clk);
        rst_n   = 1'b1;
        wr_data = 8'h01;
        rd_code = 13'h0;
        step();
        check("R1 encode 01", 32'(wr_code), 32'h1007);

        @(negedge clk);
        wr_data = 8'hFF;
        step();
        check("R2 R3 encode FF", 32'(wr_code), 32'h0F77);

        // R10: a new input must not show before the next rising edge
        @(negedge clk);
        wr_data = 8'h3C;
        #1;
        check("R10 held before edge", 32'(wr_code), 32'h0F77);
        step();
        check("R10 updated after edge", 32'(wr_code), 32'(ref_enc(8'h3C)));

        // R3: every encoded word has even weight
        for (int v = 0; v < 256; v += 37) begin
            @(negedge clk);
            wr_data = 8'(v);
            step();
            check("R3 even weight", 32'(^wr_code), 32'h0);
        end

        // R11: both paths driven together in every vector
        for (int v = 0; v < NVEC; v++) begin
            d     = VEC[v][22:15];
            flip  = VEC[v][14:2];
            cls   = VEC[v][1:0];
            exp_d = (cls == 2'd2) ? ref_pick(ref_enc(d) ^ flip) : d;
            @(negedge clk);
            wr_data = ~d;
            rd_code = ref_enc(d) ^ flip;
            step();
            check("R11 R1 R2 wr_code", 32'(wr_code), 32'(ref_enc(~d)));
            check("R4 R5 R6 R7 R8 rd_data", 32'(rd_data), 32'(exp_d));
            check("R5 R6 R9 corrected", 32'(rd_corrected), 32'(cls == 2'd1));
            check("R7 R8 R9 uncorrectable", 32'(rd_uncorrectable), 32'(cls == 2'd2));
        end

        // R10: asynchronous reset clears outputs without waiting for an edge
        @(negedge clk);
        rd_code = ref_enc(8'hC3) ^ 13'h0003;
        step();
        check("R7 before reset", 32'(rd_uncorrectable), 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 async clear data", 32'(rd_data), 32'h0);
        check("R10 async clear flag", 32'(rd_uncorrectable), 32'h0);
        check("R10 async clear code", 32'(wr_code), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R10 resumes", 32'(rd_uncorrectable), 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule